// File: doc/BRIEF.md
# Calendar Slot Arbiter with Backup Port

This block hands out buffer-access turns to ports according to a programmable calendar. The calendar is a table of up to 128 slots. Each slot names a primary port, a direction (ingress or egress) and, if wanted, a backup port. A control word selects the window of slots in use: a start index, a slot count and a run bit. While it runs, the arbiter visits one slot per clock. It grants the primary port when that port reports itself active. When the primary is idle it grants the backup port, if one is named and active. Otherwise that turn goes unused.

Software fills the table and the control word through a single write port. Port activity arrives as one flag per port. The grant leaves the block as a registered strobe with a port number and a direction bit, one cycle after the slot was read. A common way to program the table is to place the ingress slot and the egress slot of the same port next to each other.

Top module: `cal_slot_arbiter`

## Requirements
- R1: After reset no grant is issued, the control word is cleared (not running) and all table slots read as empty.
- R2: A write with `cfg_ctrl_sel`=0 stores `cfg_wdata[11:0]` into slot `cfg_idx` with this layout: primary port in bits 3:0, direction in bit 4 (1 = egress, 0 = ingress), slot-in-use in bit 5, backup-enable in bit 6, backup port in bits 11:8. When a running slot is in use and its primary port's `port_active` bit is 1, the next cycle shows `gnt_valid`=1 with that port and the slot's direction.
- R3: A slot whose in-use bit is 0 produces no grant in its turn.
- R4: When the primary port is inactive, backup-enable is 1 and the backup port is active, the grant goes to the backup port with the slot's direction.
- R5: When neither the primary nor an enabled, active backup port is available, the turn produces no grant; every grant names a port that was active in the cycle its slot was read.
- R6: A write with `cfg_ctrl_sel`=1 loads the control word: slot count in bits 7:0, start index in bits 14:8, run bit at bit 31. While running, slots are visited one per cycle from the start index through start+count-1, indices taken modulo 128, and then the visit restarts at the start index; each grant appears one cycle after its slot is read.
- R7: With the run bit at 0, or a slot count of 0, no grant is issued and the slot pointer stays at the start index, so the first turn after running again uses the start slot.
- R8: Any control write restarts the visit at the new start index on the following cycle.
- R9: A table write to the slot being read in the same cycle does not change that turn; the new content is used on the next visit.
- R10: A slot count above 128 behaves as a count of 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ctrl_sel | input | 1 | 1 = write control word, 0 = write table slot |
| cfg_idx | input | 7 | Table slot index for a slot write |
| cfg_wdata | input | 32 | Write data |
| port_active | input | 16 | One activity flag per port |
| gnt_valid | output | 1 | Grant strobe for this cycle |
| gnt_port | output | 4 | Granted port number |
| gnt_egress | output | 1 | Granted direction, 1 = egress |

## Verification
On every cycle the assertions check the following. A stopped or zero-length calendar stays silent and holds its pointer. Empty slots never grant. An active primary always wins its slot, and the backup wins only when the primary is idle. Every combinational pick names an active port. The pointer steps by one, stays inside the window and returns to the start after a control write. Only the bench's scenarios can show the rest. The visit order across wrap-around past index 127 needs them, as does the clamp of oversized counts and the old-content rule for a slot rewritten during its own turn. The bench checks all of these against an independent model of the calendar, fed the same random table contents and activity patterns.

// File: rtl/cal_arb_pkg.sv
package cal_arb_pkg;

    localparam int PORT_W     = 4;
    localparam int NPORTS     = 1 << PORT_W;
    localparam int DEPTH_W    = 8;
    localparam int OFS_W      = 7;
    localparam int CFG_W      = 32;
    localparam int SLOT_W     = 2 * PORT_W + 4;

    // control word field positions
    localparam int CTL_DEPTH_LSB = 0;
    localparam int CTL_OFS_LSB   = 8;
    localparam int CTL_RUN_BIT   = 31;

    // one calendar slot, packed in its stored bit order
    typedef struct packed {
        logic [PORT_W-1:0] alt_port;  // 11:8
        logic              pad;       // 7
        logic              alt_ok;    // 6
        logic              live;      // 5
        logic              egress;    // 4
        logic [PORT_W-1:0] port;      // 3:0
    } slot_t;

    typedef struct packed {
        logic               run;
        logic [OFS_W-1:0]   ofs;
        logic [DEPTH_W-1:0] depth;
    } ctrl_t;

    typedef struct packed {
        logic              valid;
        logic              egress;
        logic [PORT_W-1:0] port;
    } grant_t;

    function automatic slot_t unpack_slot(input logic [CFG_W-1:0] w);
        return slot_t'(w[SLOT_W-1:0]);
    endfunction

    function automatic ctrl_t unpack_ctrl(input logic [CFG_W-1:0] w);
        ctrl_t c;
        c.run   = w[CTL_RUN_BIT];
        c.ofs   = w[CTL_OFS_LSB +: OFS_W];
        c.depth = w[CTL_DEPTH_LSB +: DEPTH_W];
        return c;
    endfunction

endpackage

// File: rtl/cal_slot_table.sv
module cal_slot_table
    import cal_arb_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  slot_t            wr_slot,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_t            rd_slot
);

    slot_t mem_q [NUM_SLOTS];

    // read returns the content stored before this cycle's write
    assign rd_slot = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                mem_q[i] <= '0;
            end
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_slot;
        end
    end

endmodule

// File: rtl/cal_slot_seq.sv
module cal_slot_seq
    import cal_arb_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    localparam int IDX_W    = $clog2(NUM_SLOTS),
    localparam int SUM_W    = IDX_W + 1,
    localparam int DE_W     = DEPTH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctrl_t            ctrl,
    input  logic             ctrl_wr,
    output logic             run,
    output logic [IDX_W-1:0] slot_idx
);

    typedef struct packed {
        logic [IDX_W-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic [DE_W-1:0]  depth_eff;
    logic [SUM_W-1:0] sum;
    logic             last;

    always_comb begin
        if (DE_W'(ctrl.depth) > DE_W'(NUM_SLOTS)) begin
            depth_eff = DE_W'(NUM_SLOTS);
        end else begin
            depth_eff = DE_W'(ctrl.depth);
        end
        run  = ctrl.run && (ctrl.depth != '0);
        last = (DE_W'(st_q.cnt) == depth_eff - DE_W'(1));

        sum = SUM_W'(ctrl.ofs) + SUM_W'(st_q.cnt);
        if (sum >= SUM_W'(NUM_SLOTS)) begin
            sum = sum - SUM_W'(NUM_SLOTS);
        end
        slot_idx = IDX_W'(sum);

        st_d = st_q;
        if (ctrl_wr || !run || last) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + IDX_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: a stopped calendar keeps its pointer at the start slot
    assert_hold_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> st_q.cnt == '0);

    // R8: a control write restarts the visit
    assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> st_q.cnt == '0);

    // R6: pointer stays inside the programmed window
    assert_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> DE_W'(st_q.cnt) < depth_eff);

    // R6: one slot per cycle
    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl_wr && !last) |=> st_q.cnt == $past(st_q.cnt) + IDX_W'(1));

endmodule

// File: rtl/cal_slot_pick.sv
module cal_slot_pick
    import cal_arb_pkg::*;
(
    input  logic              run,
    input  slot_t             slot,
    input  logic [NPORTS-1:0] port_active,
    output grant_t            pick
);

    always_comb begin
        pick        = '0;
        pick.egress = slot.egress;
        if (run && slot.live) begin
            if (port_active[slot.port]) begin
                pick.valid = 1'b1;
                pick.port  = slot.port;
            end else if (slot.alt_ok && port_active[slot.alt_port]) begin
                pick.valid = 1'b1;
                pick.port  = slot.alt_port;
            end
        end
        if (!pick.valid) begin
            pick.egress = 1'b0;
        end
    end

endmodule

// File: rtl/cal_slot_arbiter.sv
module cal_slot_arbiter
    import cal_arb_pkg::*;
#(
    parameter int NUM_SLOTS = 128,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_ctrl_sel,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [NPORTS-1:0] port_active,
    output logic              gnt_valid,
    output logic [PORT_W-1:0] gnt_port,
    output logic              gnt_egress
);

    typedef struct packed {
        ctrl_t  ctrl;
        grant_t gnt;
    } arb_state_t;

    arb_state_t       st_d, st_q;
    logic             ctrl_wr, tab_wr, run;
    logic [IDX_W-1:0] slot_idx;
    slot_t            rd_slot;
    grant_t           pick;

    assign ctrl_wr = cfg_we && cfg_ctrl_sel;
    assign tab_wr  = cfg_we && !cfg_ctrl_sel;

    cal_slot_table #(.NUM_SLOTS(NUM_SLOTS)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tab_wr),
        .wr_idx  (cfg_idx),
        .wr_slot (unpack_slot(cfg_wdata)),
        .rd_idx  (slot_idx),
        .rd_slot (rd_slot)
    );

    cal_slot_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (st_q.ctrl),
        .ctrl_wr  (ctrl_wr),
        .run      (run),
        .slot_idx (slot_idx)
    );

    cal_slot_pick u_pick (
        .run         (run),
        .slot        (rd_slot),
        .port_active (port_active),
        .pick        (pick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.gnt = pick;
        if (ctrl_wr) begin
            st_d.ctrl = unpack_ctrl(cfg_wdata);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt_valid  = st_q.gnt.valid;
    assign gnt_port   = st_q.gnt.port;
    assign gnt_egress = st_q.gnt.egress;

    // R7: no turn is granted while stopped
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !gnt_valid);

    // R3: empty slots never grant
    assert_dead_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rd_slot.live) |=> !gnt_valid);

    // R5: a pick always names an active port
    assert_pick_active_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pick.valid |-> port_active[pick.port]);

    // R2: an active primary wins its slot
    assert_primary_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rd_slot.live && port_active[rd_slot.port]) |=>
        (gnt_valid && gnt_port == $past(rd_slot.port) && gnt_egress == $past(rd_slot.egress)));

    // R4: backup takes the slot only when the primary is idle
    assert_backup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && rd_slot.live && !port_active[rd_slot.port] && rd_slot.alt_ok
         && port_active[rd_slot.alt_port]) |=>
        (gnt_valid && gnt_port == $past(rd_slot.alt_port)));

endmodule

// File: tb/sim_cal_slot_arbiter.sv
module sim_cal_slot_arbiter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_ctrl_sel = 1'b0;
    logic [6:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] port_active = '0;
    logic        gnt_valid;
    logic [3:0]  gnt_port;
    logic        gnt_egress;

    int checks = 0;
    int fails  = 0;

    // independent model of the calendar
    logic [11:0] mtab [128];
    bit          m_run;
    int          m_ofs, m_depth, m_cnt;
    bit          e_v, e_eg;
    int          e_port;
    string       e_cat;

    always #5 clk = ~clk;

    cal_slot_arbiter u0 (
        .clk, .rst_n, .cfg_we, .cfg_ctrl_sel, .cfg_idx, .cfg_wdata,
        .port_active, .gnt_valid, .gnt_port, .gnt_egress
    );

    function automatic logic [31:0] mk_slot(int p, bit eg, bit live, bit aok, int ap);
        return {20'd0, 4'(ap), 1'b0, aok, live, eg, 4'(p)};
    endfunction

    function automatic logic [31:0] mk_ctrl(bit run, int ofs, int depth);
        return {run, 16'd0, 7'(ofs), 8'(depth)};
    endfunction

    task automatic compare(string phase);
        checks++;
        if (gnt_valid !== e_v || (e_v && (gnt_port !== 4'(e_port) || gnt_egress !== e_eg))) begin
            fails++;
            $display("FAIL %s (%s): got v=%0b p=%0d eg=%0b expected v=%0b p=%0d eg=%0b",
                     e_cat, phase, gnt_valid, gnt_port, gnt_egress, e_v, e_port, e_eg);
        end
    endtask

    // one clock: check outputs, drive inputs, advance model
    task automatic cyc(string phase, bit we, bit csel, int idx, logic [31:0] d, logic [15:0] act);
        int de, slot;
        logic [11:0] e;
        @(negedge clk);
        compare(phase);
        cfg_we = we; cfg_ctrl_sel = csel; cfg_idx = 7'(idx); cfg_wdata = d; port_active = act;
        de   = (m_depth > 128) ? 128 : m_depth;
        slot = (m_ofs + m_cnt) % 128;
        e    = mtab[slot];
        e_v = 0; e_eg = 0; e_port = 0;
        if (!(m_run && m_depth != 0)) e_cat = "R7";
        else if (!e[5]) e_cat = "R3";
        else if (act[e[3:0]]) begin e_v = 1; e_port = e[3:0]; e_eg = e[4]; e_cat = "R2"; end
        else if (e[6] && act[e[11:8]]) begin e_v = 1; e_port = e[11:8]; e_eg = e[4]; e_cat = "R4"; end
        else e_cat = "R5";
        if (we && !csel) mtab[idx] = d[11:0];
        if (we && csel) begin
            m_run = d[31]; m_ofs = int'(d[14:8]); m_depth = int'(d[7:0]); m_cnt = 0;
        end else if (!(m_run && m_depth != 0)) m_cnt = 0;
        else m_cnt = (m_cnt == de - 1) ? 0 : m_cnt + 1;
    endtask

    task automatic idle(string phase, int n, logic [15:0] act);
        for (int i = 0; i < n; i++) cyc(phase, 0, 0, 0, 32'd0, act);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250108));
        for (int i = 0; i < 128; i++) mtab[i] = '0;
        m_run = 0; m_ofs = 0; m_depth = 0; m_cnt = 0;
        e_v = 0; e_eg = 0; e_port = 0; e_cat = "R1";
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1", 3, 16'hFFFF);

        // directed table: ingress/egress pairs, backups, an empty slot
        cyc("R2", 1, 0, 0, mk_slot(1, 0, 1, 0, 0), 16'hFFFF);
        cyc("R2", 1, 0, 1, mk_slot(1, 1, 1, 0, 0), 16'hFFFF);
        cyc("R2", 1, 0, 2, mk_slot(2, 0, 1, 1, 5), 16'hFFFF);
        cyc("R3", 1, 0, 3, mk_slot(3, 1, 0, 1, 3), 16'hFFFF);
        cyc("R2", 1, 0, 4, mk_slot(4, 1, 1, 1, 6), 16'hFFFF);
        cyc("R2", 1, 0, 5, mk_slot(7, 0, 1, 0, 0), 16'hFFFF);
        cyc("R2", 1, 0, 6, mk_slot(0, 1, 1, 0, 0), 16'hFFFF);
        cyc("R2", 1, 0, 7, mk_slot(9, 0, 1, 1, 9), 16'hFFFF);
        idle("R7", 4, 16'hFFFF);
        cyc("R6", 1, 1, 0, mk_ctrl(1, 0, 8), 16'hFFFF);
        idle("R6", 20, 16'hFFFF);
        // primaries 2,4,7 idle: backups 5 (active) and 6 (idle)
        idle("R4", 20, 16'hFFFF & ~16'h00D4);
        idle("R5", 10, 16'h0000);
        // restart in a new window mid-run
        idle("R8", 3, 16'hFFFF);
        cyc("R8", 1, 1, 0, mk_ctrl(1, 2, 3), 16'hFFFF);
        idle("R8", 10, 16'hFFFF);
        cyc("R8", 1, 1, 0, mk_ctrl(1, 5, 2), 16'hFFFF);
        idle("R8", 6, 16'hFFFF);
        // rewrite slots during their own turns
        cyc("R9", 1, 1, 0, mk_ctrl(1, 0, 8), 16'hFFFF);
        for (int i = 0; i < 40; i++)
            cyc("R9", 1, 0, i % 8, mk_slot($urandom_range(15), 1'($urandom), 1'b1, 1'b1, $urandom_range(15)),
                16'($urandom));
        // stopped and zero-length
        cyc("R7", 1, 1, 0, mk_ctrl(1, 3, 0), 16'hFFFF);
        idle("R7", 10, 16'hFFFF);
        cyc("R7", 1, 1, 0, mk_ctrl(0, 3, 5), 16'hFFFF);
        idle("R7", 10, 16'hFFFF);
        // fill whole table randomly while stopped
        for (int i = 0; i < 128; i++)
            cyc("R7", 1, 0, i, 32'($urandom), 16'($urandom));
        // oversized count and wrap past the last index
        cyc("R10", 1, 1, 0, mk_ctrl(1, 100, 200), 16'hFFFF);
        idle("R10", 300, 16'hFFFF);
        cyc("R6", 1, 1, 0, mk_ctrl(1, 120, 20), 16'hFFFF);
        idle("R6", 60, 16'($urandom));
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(99);
            if (r < 2)
                cyc("RND", 1, 1, 0, mk_ctrl($urandom_range(9) != 0, $urandom_range(127),
                    $urandom_range(255)), 16'($urandom));
            else if (r < 20)
                cyc("RND", 1, 0, $urandom_range(127), 32'($urandom), 16'($urandom));
            else
                cyc("RND", 0, 0, 0, 32'd0, 16'($urandom) & 16'($urandom));
        end
        @(negedge clk);
        compare("END");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule